// File: doc/BRIEF.md
# Code-Selected Divider Bank with Gated Channel

This block turns small 4-bit ratio codes into periodic enable pulses. There are four channels. Each one issues a one-cycle enable once every N input clock cycles. N comes from a sparse, nonlinear lookup table, and each channel uses one of three table variants. Logic downstream uses these pulses as clock enables. The block does not generate any new clock domain.

Software sets the ratios through a write-only register port with two word-wide registers:

- **Shared register:** holds three independent ratio fields.
- **Gated register:** holds a fourth ratio field plus a stop bit. Setting the stop bit silences that channel.

A code that the channel's table does not define raises that channel's invalid flag and keeps its enable low. A code change never produces a short or stretched period, because each channel adopts a new ratio only at the end of its current period.

Top module: `clkdiv_code_bank`

## Requirements
- R1: Channel 0 uses the main table, which maps codes to periods as follows:
  - codes 0, 1, 2, 3, 4, 5, 6, 7 and 8 give periods 2, 3, 4, 6, 8, 12, 16, 18 and 24;
  - code 10 gives 36 and code 11 gives 48;
  - codes 9 and 12 to 15 are undefined.
- R2: Channels 1 and 2 use the second table, which maps codes to periods as follows:
  - codes 4 to 8, 10 and 11 give the same periods as the main table;
  - code 12 gives period 10;
  - codes 0 to 3, 9 and 13 to 15 are undefined.
- R3: Channel 3 uses the gated table, which maps codes to periods as follows:
  - codes 1 to 8, 10 and 11 give the main-table periods;
  - codes 0, 9 and 12 to 15 are undefined.
- R4: While a channel's code is undefined in its table, its `code_bad` bit is 1 and its `tick` bit stays 0. Otherwise `code_bad` is 0.
- R5: Each `tick` bit is high for exactly one cycle, once every N cycles, where N is the decoded period.
- R6: A new code takes effect at the channel's next terminal count. The period running when the write lands keeps its old length, and every later period has the new length.
- R7: Bit 8 of the gated register is a stop bit. While it is 1, `tick[3]` stays 0. `code_bad[3]` still reports whether the code is valid. Clearing the stop bit resumes pulses at the programmed period.
- R8: After synchronous reset the four codes are 0, 4, 4 and 1, which give periods 2, 8, 8 and 3. The stop bit is 0, and all `code_bad` bits are 0.
- R9: Register layout and decoding:
  - A write with `wr_sel`=0 loads channel 0 from data bits 11:8, channel 1 from bits 7:4 and channel 2 from bits 3:0.
  - A write with `wr_sel`=1 loads channel 3 from bits 3:0 and the stop bit from bit 8.
  - All other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that all channels divide |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 0 selects the shared register, 1 selects the gated register |
| wr_data | input | 32 | Write data |
| tick | output | 4 | Per-channel one-cycle enable pulses |
| code_bad | output | 4 | Per-channel flag for an undefined code |

## Verification
The hardest case to reach from the ports is a ratio change that lands partway through a running period. The stimulus first synchronises to an observed pulse on channel 0. It then counts cycles and issues the write a fixed number of cycles into a 36-cycle period. It then measures the interval that spans the write and the interval after it, one against the old length and one against the new. The invalid-code and stop-bit cases are observed over long pulse-free windows, started a few cycles after the write so that a pulse already in flight cannot be mistaken for one.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    parameter int CODE_W   = 4;
    parameter int RATIO_W  = 6;
    parameter int NCH      = 4;
    parameter int DATA_W   = 32;
    parameter int FIELD_HI = 8;   // lsb of the highest shared field
    parameter int STOP_BIT = 8;   // stop bit in the gated register

    typedef enum logic [1:0] {TBL_MAIN, TBL_SD, TBL_GATED} tbl_e;

    typedef struct packed {
        logic               ok;
        logic [RATIO_W-1:0] n;
    } ratio_t;

    function automatic ratio_t base_ratio(input logic [CODE_W-1:0] c);
        ratio_t r;
        r.ok = 1'b1;
        case (c)
            4'd0:    r.n = RATIO_W'(2);
            4'd1:    r.n = RATIO_W'(3);
            4'd2:    r.n = RATIO_W'(4);
            4'd3:    r.n = RATIO_W'(6);
            4'd4:    r.n = RATIO_W'(8);
            4'd5:    r.n = RATIO_W'(12);
            4'd6:    r.n = RATIO_W'(16);
            4'd7:    r.n = RATIO_W'(18);
            4'd8:    r.n = RATIO_W'(24);
            4'd10:   r.n = RATIO_W'(36);
            4'd11:   r.n = RATIO_W'(48);
            default: begin r.ok = 1'b0; r.n = RATIO_W'(2); end
        endcase
        return r;
    endfunction

    function automatic ratio_t decode(input tbl_e t, input logic [CODE_W-1:0] c);
        ratio_t r;
        r = base_ratio(c);
        case (t)
            TBL_SD: begin
                if (c < CODE_W'(4)) r.ok = 1'b0;
                if (c == CODE_W'(12)) begin
                    r.ok = 1'b1;
                    r.n  = RATIO_W'(10);
                end
            end
            TBL_GATED: if (c == '0) r.ok = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    function automatic tbl_e chan_table(input int i);
        if (i == 0)       return TBL_MAIN;
        if (i == NCH - 1) return TBL_GATED;
        return TBL_SD;
    endfunction

    function automatic logic [CODE_W-1:0] reset_code(input tbl_e t);
        case (t)
            TBL_MAIN: return CODE_W'(0);
            TBL_SD:   return CODE_W'(4);
            default:  return CODE_W'(1);
        endcase
    endfunction

    // lsb of a channel's field; the gated channel sits at the bottom of its own word
    function automatic int field_lsb(input int i);
        if (i == NCH - 1) return 0;
        return FIELD_HI - CODE_W * i;
    endfunction
endpackage

// File: rtl/cdb_regs.sv
module cdb_regs
    import cdb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NCH-1:0][CODE_W-1:0]    code_q,
    output logic                          gate_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) code_q[i] <= reset_code(chan_table(i));
            gate_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_sel) begin
                for (int i = 0; i < NCH - 1; i++)
                    code_q[i] <= wr_data[field_lsb(i) +: CODE_W];
            end else begin
                code_q[NCH-1] <= wr_data[field_lsb(NCH-1) +: CODE_W];
                gate_q        <= wr_data[STOP_BIT];
            end
        end
    end
endmodule

// File: rtl/cdb_decode.sv
module cdb_decode
    import cdb_pkg::*;
#(
    parameter tbl_e TBL = TBL_MAIN
) (
    input  logic [CODE_W-1:0] code,
    output ratio_t            ratio
);
    always_comb ratio = decode(TBL, code);
endmodule

// File: rtl/cdb_chan.sv
module cdb_chan #(
    parameter int               RATIO_W = 6,
    parameter logic [RATIO_W-1:0] RST_N = RATIO_W'(2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               code_ok,
    input  logic [RATIO_W-1:0] n_new,
    input  logic               run,
    output logic               tick
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] n_act;
    logic               live;
    logic               term;

    assign term = (cnt == n_act - RATIO_W'(1));
    assign tick = live && term;

    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b1;
            n_act <= RST_N;
            cnt   <= '0;
        end else if (!code_ok || !run) begin
            live <= 1'b0;
            cnt  <= '0;
        end else if (!live) begin
            live  <= 1'b1;
            n_act <= n_new;
            cnt   <= '0;
        end else if (term) begin
            n_act <= n_new;      // new ratio only at period boundary
            cnt   <= '0;
        end else begin
            cnt <= cnt + RATIO_W'(1);
        end
    end
endmodule

// File: rtl/clkdiv_code_bank.sv
module clkdiv_code_bank
    import cdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    output logic [3:0]        tick,
    output logic [3:0]        code_bad
);
    logic [NCH-1:0][CODE_W-1:0] code_q;
    logic                       gate_q;

    cdb_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .code_q (code_q),
        .gate_q (gate_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam tbl_e   T   = chan_table(g);
        localparam ratio_t RST = decode(T, reset_code(T));
        ratio_t r;
        logic   run;

        cdb_decode #(.TBL(T)) u_dec (
            .code (code_q[g]),
            .ratio(r)
        );

        if (g == NCH - 1) begin : g_gated
            assign run = !gate_q;
        end else begin : g_free
            assign run = 1'b1;
        end

        cdb_chan #(.RATIO_W(RATIO_W), .RST_N(RST.n)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .code_ok(r.ok),
            .n_new  (r.n),
            .run    (run),
            .tick   (tick[g])
        );

        assign code_bad[g] = !r.ok;
    end
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] tick,
    input logic [3:0] code_bad,
    input logic       gate_q
);
    for (genvar g = 0; g < 4; g++) begin : g_a
        a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
            tick[g] |=> !tick[g]);
        a_r4_bad_silent: assert property (@(posedge clk) disable iff (rst)
            (code_bad[g] && $past(code_bad[g])) |-> !tick[g]);
    end

    a_r7_stop_silent: assert property (@(posedge clk) disable iff (rst)
        (gate_q && $past(gate_q)) |-> !tick[3]);

    a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_bad == 4'b0 && tick == 4'b0 && !gate_q));
endmodule

bind clkdiv_code_bank cdb_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .code_bad(code_bad),
    .gate_q  (gate_q)
);

// File: tb/test_clkdiv_code_bank.sv
module test_clkdiv_code_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  tick;
    logic [3:0]  code_bad;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clkdiv_code_bank i_clkdiv_code_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .code_bad(code_bad)
    );

    typedef struct packed {
        logic        sel;
        logic [31:0] data;
        logic [1:0]  ch;
        logic [5:0]  per;
        logic        bad;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        {1'b0, 32'h0000_0044, 2'd0, 6'd2,  1'b0},
        {1'b0, 32'h0000_0B44, 2'd0, 6'd48, 1'b0},
        {1'b0, 32'h0000_0944, 2'd0, 6'd0,  1'b1},
        {1'b0, 32'h0000_0A44, 2'd0, 6'd36, 1'b0},
        {1'b0, 32'h0000_07C4, 2'd1, 6'd10, 1'b0},
        {1'b0, 32'h0000_0734, 2'd1, 6'd0,  1'b1},
        {1'b0, 32'h0000_0758, 2'd2, 6'd24, 1'b0},
        {1'b0, 32'h0000_0759, 2'd2, 6'd0,  1'b1},
        {1'b0, 32'hFFFF_F05B, 2'd2, 6'd48, 1'b0},
        {1'b1, 32'h0000_0001, 2'd3, 6'd3,  1'b0},
        {1'b1, 32'h0000_0000, 2'd3, 6'd0,  1'b1},
        {1'b1, 32'h0000_0006, 2'd3, 6'd16, 1'b0},
        {1'b1, 32'hFFFF_FE0C, 2'd3, 6'd0,  1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // assumes the current negedge shows a tick on ch; counts to the next one
    task automatic to_next(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[ch] && n < 200);
        if (!tick[ch]) n = 0;
    endtask

    task automatic period(input int ch, output int n);
        int w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!tick[ch] && w < 200);
        if (!tick[ch]) n = 0;
        else to_next(ch, n);
    endtask

    task automatic quiet(input int ch, output int cnt);
        cnt = 0;
        repeat (3) @(negedge clk);
        repeat (120) begin
            @(negedge clk);
            if (tick[ch]) cnt++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p;
        int q;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 code_bad after reset", int'(code_bad), 0);
        period(0, p); chk("R8 ch0 reset period", p, 2);
        period(1, p); chk("R8 ch1 reset period", p, 8);
        period(2, p); chk("R8 ch2 reset period", p, 8);
        period(3, p); chk("R8 ch3 reset period", p, 3);

        // vector walk: R1 R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].sel, VEC[i].data);
            if (VEC[i].bad) tag = "R4";
            else if (VEC[i].ch == 2'd0) tag = "R1";
            else if (VEC[i].ch == 2'd3) tag = "R3";
            else tag = "R2";
            if (i == 8 || i == 12) tag = {tag, "/R9"};
            if (VEC[i].bad) begin
                quiet(int'(VEC[i].ch), q);
                chk({tag, " tick count on undefined code"}, q, 0);
            end else begin
                period(int'(VEC[i].ch), p);
                chk({tag, " period"}, p, int'(VEC[i].per));
            end
            chk({tag, " code_bad"}, int'(code_bad[VEC[i].ch]), int'(VEC[i].bad));
        end

        // R7 stop bit
        wr(1'b1, 32'h0000_0108);
        quiet(3, q);
        chk("R7 ticks while stopped", q, 0);
        chk("R7 code_bad while stopped, valid code", int'(code_bad[3]), 0);
        wr(1'b1, 32'h0000_0008);
        period(3, p);
        chk("R7 period after restart", p, 24);
        wr(1'b1, 32'h0000_0109);
        repeat (2) @(negedge clk);
        chk("R7 code_bad while stopped, bad code", int'(code_bad[3]), 1);

        // R6 mid-period ratio change on ch0
        wr(1'b0, 32'h0000_0A5B);
        period(0, p);
        chk("R6 setup period", p, 36);
        begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
                if (n == 5) begin
                    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_035B;
                end else if (n == 6) begin
                    wr_en = 1'b0;
                end
            end while (!tick[0] && n < 200);
            chk("R6 period spanning write", n, 36);
        end
        to_next(0, p);
        chk("R6 first new period", p, 6);
        to_next(0, p);
        chk("R5 steady period", p, 6);
        @(negedge clk);
        chk("R5 single-cycle pulse", int'(tick[0]), 0);

        // R8 reset in mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        chk("R8 code_bad after second reset", int'(code_bad), 0);
        period(0, p); chk("R8 ch0 after second reset", p, 2);
        period(3, p); chk("R8 ch3 after second reset", p, 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule